// File: doc/BRIEF.md
# Dual-Line GPIO Interrupt Controller

This block is a general-purpose I/O port with up to 32 pins behind a 32-bit register bus. Each pin is either an input or a driven output. Input pins can be watched for four kinds of event: a rising edge, a falling edge, a high level or a low level. Each detected event is latched into two separate status registers. Each status register has its own enable register, which produces an interrupt line of its own. Two processors or two priority levels can therefore take the same pin events independently.

A third output, the wakeup flag, is raised by an enabled pin event only when the idle configuration allows it. The flag is sticky until a reset. Enable registers and output data have set and clear alias addresses, so single bits can be changed without a read-modify-write sequence. Writing the configuration register with its reset bit set returns the register state to its defaults without touching the output data.

The bus is a single-cycle strobe interface. A write commits on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr`.

Top module: `gpio_dual_irq`

## Requirements
- R1: After a hard reset the registers read as follows: configuration 0, control 2, direction all ones, all enables, status, detect and debounce registers 0, output data 0. `irq0`, `irq1` and `wake` are low.
- R2: Register reads work as follows:
  - Offset 0x00 returns the REV parameter, and offset 0x14 always returns 1.
  - Offset 0x38 returns the registered pin inputs.
  - The configuration register (0x10) stores the written value ANDed with 0x1D, the control register (0x30) stores the value ANDed with 0x7, and the debounce time register (0x54) keeps 8 bits.
  - An unmapped offset reads 0.
- R3: Direction (0x34) bit 1 means input. `pin_oe` is the inverse of direction, and `pin_out` equals output data (0x3C) masked to output-direction pins.
- R4: The alias offsets are:
  - 0x60 clears and 0x64 sets bits of enable 0 (0x1C).
  - 0x70 clears and 0x74 sets bits of enable 1 (0x2C).
  - 0x80 clears and 0x84 sets bits of wakeup enable (0x20).
  - 0x90 clears and 0x94 sets bits of output data.
  - Reading an alias returns the underlying register.
- R5: A rising edge with rising detect (0x48) set, or a falling edge with falling detect (0x4C) set, on an input-direction pin sets that pin's bit in both status registers (0x18, 0x28). Events on output-direction pins are ignored.
- R6: A pin that is high with high-level detect (0x44) set, or low with low-level detect (0x40) set, sets its status bits in every cycle the condition holds. Such a bit therefore re-asserts immediately after being cleared.
- R7: A write to direction or to either level-detect register re-evaluates the level conditions with the new values and sets status bits for pins that now qualify.
- R8: Writing ones to a status register clears those bits of that line only.
- R9: `irq0` is high exactly when status 0 AND enable 0 is nonzero. The same rule holds for `irq1` with status 1 and enable 1.
- R10: `wake` rises after an event on a pin whose wakeup enable bit is set, only if configuration bit 2 is set and configuration bits [4:3] are nonzero. Once high it stays high until a reset.
- R11: A configuration write with bit 1 set acts as a soft reset. It restores the R1 values of every register except output data and the input sampler, clears `wake`, and stores the written configuration ANDed with 0x1D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NPIN | Pin levels, synchronous to `clk` |
| pin_out | output | NPIN | Output levels, zero on input pins |
| pin_oe | output | NPIN | Output enables, one per output pin |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| wake | output | 1 | Sticky wakeup request |

## Verification
The bench builds the block with the full 32 pins and a revision value of 0x25 rather than the default. This puts both halves of the port in play: the low half is set as outputs while events arrive on the high half. It also shows that the revision parameter reaches the read mux. With 32 pins, a mixed direction word can be used to prove that an edge on an output pin leaves both status registers untouched. It also lets the bench walk the level-detect re-check through a direction change on a single bit.

// File: rtl/gpio_pkg.sv
// Package: shared bus width and the register offset map of the dual-line
// GPIO block. Offsets are fixed because software decodes them.
package gpio_pkg;
    localparam int DW = 32;

    localparam logic [7:0] OFS_REV     = 8'h00;
    localparam logic [7:0] OFS_CFG     = 8'h10;
    localparam logic [7:0] OFS_SYSSTAT = 8'h14;
    localparam logic [7:0] OFS_ST0     = 8'h18;
    localparam logic [7:0] OFS_EN0     = 8'h1C;
    localparam logic [7:0] OFS_WKEN    = 8'h20;
    localparam logic [7:0] OFS_ST1     = 8'h28;
    localparam logic [7:0] OFS_EN1     = 8'h2C;
    localparam logic [7:0] OFS_CTRL    = 8'h30;
    localparam logic [7:0] OFS_DIR     = 8'h34;
    localparam logic [7:0] OFS_IN      = 8'h38;
    localparam logic [7:0] OFS_OUT     = 8'h3C;
    localparam logic [7:0] OFS_LOW     = 8'h40;
    localparam logic [7:0] OFS_HIGH    = 8'h44;
    localparam logic [7:0] OFS_RISE    = 8'h48;
    localparam logic [7:0] OFS_FALL    = 8'h4C;
    localparam logic [7:0] OFS_DBEN    = 8'h50;
    localparam logic [7:0] OFS_DBTIME  = 8'h54;
    localparam logic [7:0] OFS_EN0_CLR = 8'h60;
    localparam logic [7:0] OFS_EN0_SET = 8'h64;
    localparam logic [7:0] OFS_EN1_CLR = 8'h70;
    localparam logic [7:0] OFS_EN1_SET = 8'h74;
    localparam logic [7:0] OFS_WK_CLR  = 8'h80;
    localparam logic [7:0] OFS_WK_SET  = 8'h84;
    localparam logic [7:0] OFS_OUT_CLR = 8'h90;
    localparam logic [7:0] OFS_OUT_SET = 8'h94;

    localparam logic [4:0] CFG_KEEP  = 5'h1D;
    localparam logic [2:0] CTRL_INIT = 3'h2;
    localparam int         SRST_BIT  = 1;

    // Per-line offsets, indexed by interrupt line number.
    localparam logic [7:0] OFS_STX   [2] = '{OFS_ST0,     OFS_ST1};
    localparam logic [7:0] OFS_ENX   [2] = '{OFS_EN0,     OFS_EN1};
    localparam logic [7:0] OFS_ENXCLR[2] = '{OFS_EN0_CLR, OFS_EN1_CLR};
    localparam logic [7:0] OFS_ENXSET[2] = '{OFS_EN0_SET, OFS_EN1_SET};
endpackage

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Register file and bus decode for the dual-line GPIO block.
// Assumes single-cycle writes (bus_en & bus_we) and combinational reads.
// A configuration write with the soft-reset bit restores defaults for every
// register held here except output data.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int          NPIN = 32,
    parameter logic [7:0]  REV  = 8'h18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [7:0]            bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [1:0][NPIN-1:0]  st,
    input  logic [NPIN-1:0]       inp,
    output logic [4:0]            cfg_q,
    output logic [NPIN-1:0]       dir_q,
    output logic [NPIN-1:0]       low_q,
    output logic [NPIN-1:0]       high_q,
    output logic [NPIN-1:0]       rise_q,
    output logic [NPIN-1:0]       fall_q,
    output logic [NPIN-1:0]       wken_q,
    output logic [NPIN-1:0]       out_q,
    output logic [1:0][NPIN-1:0]  en_q,
    output logic [1:0][NPIN-1:0]  clr,
    output logic                  soft_rst,
    output logic                  recheck
);
    localparam logic [NPIN-1:0] ONES = '1;

    logic            wr;
    logic [NPIN-1:0] wv;
    logic [2:0]      ctrl_q;
    logic [NPIN-1:0] dben_q;
    logic [7:0]      dbtime_q;

    assign wr       = bus_en & bus_we;
    assign wv       = bus_wdata[NPIN-1:0];
    assign soft_rst = wr && (bus_addr == OFS_CFG) && bus_wdata[SRST_BIT];

    // Configuration, detect, direction, debounce storage and re-check flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q    <= (!rst_n) ? 5'h0 : (bus_wdata[4:0] & CFG_KEEP);
            ctrl_q   <= CTRL_INIT;
            dir_q    <= ONES;
            low_q    <= '0;
            high_q   <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            wken_q   <= '0;
            dben_q   <= '0;
            dbtime_q <= '0;
            recheck  <= 1'b0;
        end else begin
            recheck <= wr && ((bus_addr == OFS_DIR) || (bus_addr == OFS_LOW) ||
                              (bus_addr == OFS_HIGH));
            if (wr) begin
                case (bus_addr)
                    OFS_CFG:    cfg_q    <= bus_wdata[4:0] & CFG_KEEP;
                    OFS_CTRL:   ctrl_q   <= bus_wdata[2:0];
                    OFS_DIR:    dir_q    <= wv;
                    OFS_LOW:    low_q    <= wv;
                    OFS_HIGH:   high_q   <= wv;
                    OFS_RISE:   rise_q   <= wv;
                    OFS_FALL:   fall_q   <= wv;
                    OFS_WKEN:   wken_q   <= wv;
                    OFS_WK_CLR: wken_q   <= wken_q & ~wv;
                    OFS_WK_SET: wken_q   <= wken_q | wv;
                    OFS_DBEN:   dben_q   <= wv;
                    OFS_DBTIME: dbtime_q <= bus_wdata[7:0];
                    default:    ;
                endcase
            end
        end
    end

    // Output data: survives soft reset, changed by plain, clear and set writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_OUT:     out_q <= wv;
                OFS_OUT_CLR: out_q <= out_q & ~wv;
                OFS_OUT_SET: out_q <= out_q | wv;
                default:     ;
            endcase
        end
    end

    // Per-line enable registers and status clear masks.
    for (genvar k = 0; k < 2; k++) begin : g_line
        // Enable register k with its set and clear aliases.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                en_q[k] <= '0;
            end else if (wr) begin
                if (bus_addr == OFS_ENX[k])         en_q[k] <= wv;
                else if (bus_addr == OFS_ENXCLR[k]) en_q[k] <= en_q[k] & ~wv;
                else if (bus_addr == OFS_ENXSET[k]) en_q[k] <= en_q[k] | wv;
            end
        end
        // Write-one-to-clear mask for status register k.
        assign clr[k] = (wr && bus_addr == OFS_STX[k]) ? wv : '0;
    end

    // Read mux: aliases return the register they modify.
    always_comb begin
        case (bus_addr)
            OFS_REV:                              bus_rdata = DW'(REV);
            OFS_CFG:                              bus_rdata = DW'(cfg_q);
            OFS_SYSSTAT:                          bus_rdata = DW'(1);
            OFS_ST0:                              bus_rdata = DW'(st[0]);
            OFS_EN0, OFS_EN0_CLR, OFS_EN0_SET:    bus_rdata = DW'(en_q[0]);
            OFS_WKEN, OFS_WK_CLR, OFS_WK_SET:     bus_rdata = DW'(wken_q);
            OFS_ST1:                              bus_rdata = DW'(st[1]);
            OFS_EN1, OFS_EN1_CLR, OFS_EN1_SET:    bus_rdata = DW'(en_q[1]);
            OFS_CTRL:                             bus_rdata = DW'(ctrl_q);
            OFS_DIR:                              bus_rdata = DW'(dir_q);
            OFS_IN:                               bus_rdata = DW'(inp);
            OFS_OUT, OFS_OUT_CLR, OFS_OUT_SET:    bus_rdata = DW'(out_q);
            OFS_LOW:                              bus_rdata = DW'(low_q);
            OFS_HIGH:                             bus_rdata = DW'(high_q);
            OFS_RISE:                             bus_rdata = DW'(rise_q);
            OFS_FALL:                             bus_rdata = DW'(fall_q);
            OFS_DBEN:                             bus_rdata = DW'(dben_q);
            OFS_DBTIME:                           bus_rdata = DW'(dbtime_q);
            default:                              bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_detect.sv
// Module: gpio_detect
// Samples the pins once per clock and flags events on input-direction pins.
// Assumes pin_in is already synchronous to clk. Edges compare pin_in with the
// previous sample; levels hold for every cycle the condition is true.
module gpio_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] low_en,
    input  logic [NPIN-1:0] high_en,
    input  logic [NPIN-1:0] rise_en,
    input  logic [NPIN-1:0] fall_en,
    output logic [NPIN-1:0] inp_q,
    output logic [NPIN-1:0] evt,
    output logic [NPIN-1:0] lvl
);
    // Input sampler: holds the last pin value seen.
    always_ff @(posedge clk) begin
        if (!rst_n) inp_q <= '0;
        else        inp_q <= pin_in;
    end

    // Event on the incoming sample: edges against the held value, or levels.
    always_comb begin
        evt = dir & ((pin_in  & ((rise_en & ~inp_q) | high_en)) |
                     (~pin_in & ((fall_en &  inp_q) | low_en)));
    end

    // Level condition on the held sample, used for status re-checks.
    always_comb begin
        lvl = dir & ((inp_q & high_en) | (~inp_q & low_en));
    end
endmodule

// File: rtl/gpio_irq_line.sv
// Module: gpio_irq_line
// One interrupt line: a status register fed by pin events, write-one-to-clear,
// and an interrupt output from status AND enable. A clear that hits a set
// bit, or a re-check request, merges in the current level conditions.
module gpio_irq_line #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [NPIN-1:0] evt,
    input  logic [NPIN-1:0] clr,
    input  logic [NPIN-1:0] lvl,
    input  logic            recheck,
    input  logic [NPIN-1:0] en,
    output logic [NPIN-1:0] st_q,
    output logic            irq
);
    logic hit;

    assign hit = |(st_q & clr);

    // Status update: clear, then merge events and level re-check.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) st_q <= '0;
        else st_q <= (st_q & ~clr) | evt | ((hit || recheck) ? lvl : '0);
    end

    // Interrupt request from enabled status.
    assign irq = |(st_q & en);
endmodule

// File: rtl/gpio_dual_irq.sv
// Module: gpio_dual_irq (top)
// Register-programmed GPIO port with two interrupt lines and a sticky wakeup
// flag. Assumes pin_in is synchronous to clk. Output data is driven only on
// pins whose direction bit is 0.
module gpio_dual_irq
    import gpio_pkg::*;
#(
    parameter int         NPIN = 32,
    parameter logic [7:0] REV  = 8'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq0,
    output logic            irq1,
    output logic            wake
);
    logic [4:0]            cfg_q;
    logic [NPIN-1:0]       dir_q, low_q, high_q, rise_q, fall_q, wken_q, out_q;
    logic [1:0][NPIN-1:0]  en_q, clr, st;
    logic [NPIN-1:0]       inp_q, evt, lvl;
    logic                  soft_rst, recheck;
    logic [1:0]            irq_v;
    logic                  wake_q, wake_ok;

    gpio_regs #(.NPIN(NPIN), .REV(REV)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st(st), .inp(inp_q), .cfg_q(cfg_q), .dir_q(dir_q), .low_q(low_q),
        .high_q(high_q), .rise_q(rise_q), .fall_q(fall_q), .wken_q(wken_q),
        .out_q(out_q), .en_q(en_q), .clr(clr), .soft_rst(soft_rst),
        .recheck(recheck)
    );

    gpio_detect #(.NPIN(NPIN)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir_q),
        .low_en(low_q), .high_en(high_q), .rise_en(rise_q), .fall_en(fall_q),
        .inp_q(inp_q), .evt(evt), .lvl(lvl)
    );

    for (genvar k = 0; k < 2; k++) begin : g_irq
        gpio_irq_line #(.NPIN(NPIN)) u_line (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt),
            .clr(clr[k]), .lvl(lvl), .recheck(recheck), .en(en_q[k]),
            .st_q(st[k]), .irq(irq_v[k])
        );
    end

    // Wakeup is allowed only with bit 2 set and a nonzero idle mode.
    assign wake_ok = cfg_q[2] && (cfg_q[4:3] != 2'b00);

    // Sticky wakeup flag, cleared by hard or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)              wake_q <= 1'b0;
        else if (wake_ok && |(evt & wken_q)) wake_q <= 1'b1;
    end

    assign pin_oe  = ~dir_q;
    assign pin_out = out_q & ~dir_q;
    assign irq0    = irq_v[0];
    assign irq1    = irq_v[1];
    assign wake    = wake_q;
endmodule

// File: rtl/gpio_dual_irq_chk.sv
// Module: gpio_dual_irq_chk
// Property checker attached to gpio_dual_irq through bind.
module gpio_dual_irq_chk #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic [4:0]      cfg,
    input logic [NPIN-1:0] evt,
    input logic [NPIN-1:0] lvl,
    input logic [NPIN-1:0] wken,
    input logic [NPIN-1:0] st0,
    input logic [NPIN-1:0] st1,
    input logic [NPIN-1:0] clr0,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic            wake
);
    // R3: nothing is driven on a pin whose output enable is low
    a_r3_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R5: an event lands in both status registers
    a_r5_both_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt && !soft_rst) |=> ((st0 & st1 & $past(evt)) == $past(evt)));

    // R8: cleared bits stay clear unless an event or level refilled them
    a_r8_clear_line0: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr0 && !soft_rst) |=>
            ((st0 & $past(clr0) & ~$past(evt) & ~$past(lvl)) == '0));

    // R10: wakeup stays up until a reset
    a_r10_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !soft_rst) |=> wake);

    // R10: wakeup rises only under the permitted configuration
    a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(cfg[2] && (cfg[4:3] != 2'b00) && |(evt & wken)));

    // R11: soft reset clears wakeup, status and output drive
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!wake && st0 == '0 && st1 == '0 && pin_oe == '0));
endmodule

bind gpio_dual_irq gpio_dual_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg(cfg_q), .evt(evt),
    .lvl(lvl), .wken(wken_q), .st0(st[0]), .st1(st[1]), .clr0(clr[0]),
    .pin_out(pin_out), .pin_oe(pin_oe), .wake(wake)
);

// File: tb/sim_gpio_dual_irq.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares
// them against the outputs shortly after the clock edge that commits them.
module sim_gpio_dual_irq;
    localparam int NPIN = 32;

    localparam int K_REG  = 0;
    localparam int K_IRQ  = 1;
    localparam int K_WAKE = 2;
    localparam int K_OUT  = 3;
    localparam int K_OE   = 4;

    typedef struct {
        int          kind;
        logic [31:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic            irq0, irq1, wake;

    item_t q[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    gpio_dual_irq #(.NPIN(NPIN), .REV(8'h25)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq0(irq0), .irq1(irq1), .wake(wake)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.kind = K_REG; it.addr = 32'(a); it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic expect_out(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = kind; it.addr = '0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [NPIN-1:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    // Monitor: pops queued items after each edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                case (it.kind)
                    K_REG:   got = bus_rdata;
                    K_IRQ:   got = {30'd0, irq1, irq0};
                    K_WAKE:  got = {31'd0, wake};
                    K_OUT:   got = 32'(pin_out);
                    default: got = 32'(pin_oe);
                endcase
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%h got=%h exp=%h", it.tag, it.addr, got, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, 32'h0, "R1 cfg");
        rd(8'h30, 32'h2, "R1 ctrl");
        rd(8'h34, 32'hFFFF_FFFF, "R1 dir");
        rd(8'h18, 32'h0, "R1 st0");
        rd(8'h28, 32'h0, "R1 st1");
        rd(8'h1C, 32'h0, "R1 en0");
        rd(8'h3C, 32'h0, "R1 out");
        expect_out(K_IRQ, 32'h0, "R1 irq");
        expect_out(K_WAKE, 32'h0, "R1 wake");
        // R2 constant and identity reads
        rd(8'h00, 32'h25, "R2 rev");
        rd(8'h14, 32'h1, "R2 sysstat");
        rd(8'h58, 32'h0, "R2 unmapped");

        // R3 output drive, R4 output aliases
        wr(8'h34, 32'hFFFF_0000);
        wr(8'h3C, 32'h1234_5678);
        expect_out(K_OUT, 32'h0000_5678, "R3 pin_out");
        expect_out(K_OE, 32'h0000_FFFF, "R3 pin_oe");
        wr(8'h94, 32'h0000_0081);
        rd(8'h3C, 32'h1234_56F9, "R4 out set");
        wr(8'h90, 32'h0000_0600);
        rd(8'h94, 32'h1234_50F9, "R4 out clr alias read");
        expect_out(K_OUT, 32'h0000_50F9, "R3 pin_out after aliases");

        // R5 edges, R9 irq, R8 clear, R4 enable aliases
        wr(8'h48, 32'h0001_0001);
        wr(8'h64, 32'h0001_0001);
        rd(8'h1C, 32'h0001_0001, "R4 en0 set");
        set_pins(32'h0000_0001);
        rd(8'h18, 32'h0, "R5 output pin ignored");
        set_pins(32'h0001_0001);
        rd(8'h18, 32'h0001_0000, "R5 rise st0");
        rd(8'h28, 32'h0001_0000, "R5 rise st1");
        expect_out(K_IRQ, 32'h1, "R9 irq0 only");
        set_pins(32'h0000_0001);
        rd(8'h18, 32'h0001_0000, "R5 fall without detect");
        rd(8'h38, 32'h0000_0001, "R2 input reg");
        wr(8'h18, 32'h0001_0000);
        rd(8'h18, 32'h0, "R8 st0 cleared");
        rd(8'h28, 32'h0001_0000, "R8 st1 kept");
        expect_out(K_IRQ, 32'h0, "R9 irq0 drops");
        wr(8'h74, 32'h0001_0000);
        rd(8'h2C, 32'h0001_0000, "R4 en1 set");
        expect_out(K_IRQ, 32'h2, "R9 irq1 on enable");
        wr(8'h70, 32'h0001_0000);
        expect_out(K_IRQ, 32'h0, "R9 irq1 off after clr alias");
        wr(8'h28, 32'h0001_0000);
        rd(8'h28, 32'h0, "R8 st1 cleared");

        // R6 level high re-asserts after clear
        wr(8'h44, 32'h0002_0000);
        set_pins(32'h0002_0001);
        rd(8'h18, 32'h0002_0000, "R6 high level");
        wr(8'h18, 32'h0002_0000);
        rd(8'h18, 32'h0002_0000, "R6 reassert after clear");
        set_pins(32'h0000_0001);
        wr(8'h18, 32'h0002_0000);
        wr(8'h28, 32'h0002_0000);
        rd(8'h18, 32'h0, "R6 clear after level gone");
        wr(8'h44, 32'h0);

        // R7 direction write brings a low-level pin into play
        wr(8'h34, 32'hFFFB_0000);
        wr(8'h40, 32'h0004_0000);
        rd(8'h18, 32'h0, "R7 output pin no level");
        wr(8'h34, 32'hFFFF_0000);
        rd(8'h18, 32'h0004_0000, "R7 recheck st0");
        rd(8'h28, 32'h0004_0000, "R7 recheck st1");
        wr(8'h40, 32'h0);
        wr(8'h18, 32'h0004_0000);
        wr(8'h28, 32'h0004_0000);
        rd(8'h18, 32'h0, "R7 cleanup");

        // R10 wakeup gating and stickiness
        wr(8'h48, 32'h0008_0000);
        wr(8'h84, 32'h0008_0000);
        rd(8'h80, 32'h0008_0000, "R4 wken alias read");
        wr(8'h10, 32'h0000_0004);
        rd(8'h10, 32'h4, "R2 cfg store");
        set_pins(32'h0008_0001);
        expect_out(K_WAKE, 32'h0, "R10 no wake with zero idle mode");
        set_pins(32'h0000_0001);
        wr(8'h10, 32'h0000_000C);
        set_pins(32'h0008_0001);
        expect_out(K_WAKE, 32'h1, "R10 wake raised");
        set_pins(32'h0000_0001);
        expect_out(K_WAKE, 32'h1, "R10 wake sticky");

        // R2 masking, R11 soft reset
        wr(8'h30, 32'h0000_00FF);
        rd(8'h30, 32'h7, "R2 ctrl mask");
        wr(8'h10, 32'h0000_001F);
        rd(8'h10, 32'h1D, "R11 cfg masked");
        expect_out(K_WAKE, 32'h0, "R11 wake cleared");
        rd(8'h30, 32'h2, "R11 ctrl");
        rd(8'h34, 32'hFFFF_FFFF, "R11 dir");
        rd(8'h18, 32'h0, "R11 st0");
        rd(8'h1C, 32'h0, "R11 en0");
        rd(8'h20, 32'h0, "R11 wken");
        rd(8'h48, 32'h0, "R11 rise");
        rd(8'h3C, 32'h1234_50F9, "R11 out kept");
        expect_out(K_OUT, 32'h0, "R11 pin_out");
        expect_out(K_OE, 32'h0, "R11 pin_oe");
        wr(8'h50, 32'hAAAA_5555);
        rd(8'h50, 32'hAAAA_5555, "R2 debounce enable");
        wr(8'h54, 32'h0000_01FF);
        rd(8'h54, 32'hFF, "R2 debounce time width");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule